// File: doc/BRIEF.md
# QPSK Costas Carrier Tracking Loop

This block is the control core of a second-order, all-digital Costas loop for a QPSK receiver running at an intermediate frequency. It takes signed in-phase and quadrature arm samples that have already been mixed down and low-pass filtered. From each accepted sample it forms a decision-directed phase error without any multiplier: the sign bit of each arm picks the other arm or its negation.

Errors are summed over blocks of eight accepted samples. Each block sum drives a proportional-integral loop filter with programmable gains and a saturating integrator. Once per block the filter output is added to a fixed carrier word, and optionally to an externally loaded coarse frequency word, to form the oscillator frequency control word. An oscillator clocked at fs produces fs·W/2^32 from a control word W.

The default carrier word corresponds to a 4 MHz carrier sampled at 26 MHz (660764199). The sine/cosine lookup, the mixers and the arm filters sit outside the block.

Top module: `costas_qpsk_track`

## Requirements
- R1: During and right after a synchronous reset, `fcw_out` equals the carrier word, `fcw_valid` is 0, and the integrator, the block counter, the block sum and the coarse register are cleared.
- R2: Each accepted sample gives error e = a − b. Here a = −Q when the I MSB is 1, otherwise +Q, and b = −I when the Q MSB is 1, otherwise +I. A zero arm counts as positive.
- R3: `fcw_valid` is high for exactly one cycle, the cycle after the eighth accepted sample of a block. Cycles with `in_valid` low are ignored, whatever their data.
- R4: `fcw_out` holds its value on every cycle in which `fcw_valid` is low.
- R5: With block sum E, the proportional term is (prop_gain·E) >>> P_SHIFT (default 16), clipped to the signed 32-bit range. The gains are signed 16-bit values.
- R6: At each block the integrator becomes integrator + ((int_gain·E) >>> I_SHIFT), with I_SHIFT defaulting to 20.
- R7: The new control word is (carrier word + proportional term + updated integrator + coarse term) modulo 2^32.
- R8: A cycle with `coarse_load` high latches `coarse_word`. The coarse term is the latched word when `coarse_en` is high on the update cycle, and 0 otherwise.
- R9: The integrator saturates at +2^31−1 and −2^31 instead of wrapping.
- R10: A reset in the middle of a block discards the samples already accepted, so the next update needs eight fresh samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Arm samples valid this cycle |
| i_in | input | 32 | Filtered in-phase arm, signed |
| q_in | input | 32 | Filtered quadrature arm, signed |
| prop_gain | input | 16 | Proportional gain, signed |
| int_gain | input | 16 | Integral gain, signed |
| coarse_word | input | 32 | Coarse frequency word |
| coarse_load | input | 1 | Latch `coarse_word` |
| coarse_en | input | 1 | Add the latched coarse word |
| fcw_out | output | 32 | Oscillator frequency control word |
| fcw_valid | output | 1 | One-cycle pulse on each new word |

## Verification
On every cycle, the assertions check the cadence of the output strobe against an independent count of accepted samples, the hold of the control word between updates, and the state just after reset. The arithmetic can only be shown by the bench's directed scenarios, which compare each new word against a model built from the requirements. That arithmetic covers the sign-selected error for every sign combination and for zero arms, the proportional and integral scaling, the coarse word with its enable, saturation of the integrator in both directions, and a reset that arrives part way through a block.

// File: rtl/costas_qpsk_track.sv
module costas_qpsk_track #(
  parameter int DW = 32,
  parameter int WW = 32,
  parameter int CW = 16,
  parameter int P_SHIFT = 16,
  parameter int I_SHIFT = 20,
  parameter int BLK = 8,
  parameter logic [WW-1:0] CARRIER_WORD = 32'd660764199
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] i_in,
  input  logic [DW-1:0] q_in,
  input  logic [CW-1:0] prop_gain,
  input  logic [CW-1:0] int_gain,
  input  logic [WW-1:0] coarse_word,
  input  logic          coarse_load,
  input  logic          coarse_en,
  output logic [WW-1:0] fcw_out,
  output logic          fcw_valid
);
  localparam int EW   = DW + 2;
  localparam int CNTW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int SW   = EW + CNTW;
  localparam int PW   = SW + CW;
  localparam logic signed [PW:0] W_MAX = (PW+1)'({1'b0, {(WW-1){1'b1}}});
  localparam logic signed [PW:0] W_MIN = -W_MAX - 1;

  logic [CNTW-1:0]        cnt;
  logic signed [SW-1:0]   acc;
  logic signed [WW-1:0]   integ;
  logic [WW-1:0]          coarse_q;

  logic signed [EW-1:0] i_x, q_x, term_a, term_b, err;
  logic signed [SW-1:0] blk_sum;
  logic signed [PW-1:0] prod_p, prod_i;
  logic signed [PW:0]   p_sh, i_sum;
  logic signed [WW-1:0] prop_c, integ_nx;
  logic [WW-1:0]        fcw_nx;
  logic                 last;

  function automatic logic signed [WW-1:0] clip(input logic signed [PW:0] v);
    if (v > W_MAX) return W_MAX[WW-1:0];
    if (v < W_MIN) return W_MIN[WW-1:0];
    return v[WW-1:0];
  endfunction

  assign i_x    = {{2{i_in[DW-1]}}, i_in};
  assign q_x    = {{2{q_in[DW-1]}}, q_in};
  assign term_a = i_in[DW-1] ? -q_x : q_x;
  assign term_b = q_in[DW-1] ? -i_x : i_x;
  assign err    = term_a - term_b;

  assign blk_sum = acc + {{CNTW{err[EW-1]}}, err};
  assign last    = (cnt == CNTW'(BLK - 1));

  assign prod_p = $signed(prop_gain) * blk_sum;
  assign prod_i = $signed(int_gain) * blk_sum;
  assign p_sh   = {prod_p[PW-1], prod_p >>> P_SHIFT};
  assign i_sum  = {{(PW+1-WW){integ[WW-1]}}, integ} + {prod_i[PW-1], prod_i >>> I_SHIFT};

  assign prop_c   = clip(p_sh);
  assign integ_nx = clip(i_sum);
  assign fcw_nx   = CARRIER_WORD + prop_c + integ_nx + (coarse_en ? coarse_q : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      acc       <= '0;
      integ     <= '0;
      coarse_q  <= '0;
      fcw_out   <= CARRIER_WORD;
      fcw_valid <= 1'b0;
    end else begin
      fcw_valid <= 1'b0;
      if (coarse_load) coarse_q <= coarse_word;
      if (in_valid) begin
        if (last) begin
          cnt       <= '0;
          acc       <= '0;
          integ     <= integ_nx;
          fcw_out   <= fcw_nx;
          fcw_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          acc <= blk_sum;
        end
      end
    end
  end
endmodule

// File: rtl/costas_qpsk_track_chk.sv
module costas_qpsk_track_chk #(
  parameter int WW = 32,
  parameter int BLK = 8,
  parameter logic [WW-1:0] CARRIER_WORD = 32'd660764199
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [WW-1:0] fcw_out,
  input logic          fcw_valid
);
  int   ck_cnt;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_cnt <= 0;
      armed  <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (in_valid) ck_cnt <= (ck_cnt == BLK - 1) ? 0 : ck_cnt + 1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (fcw_out == CARRIER_WORD && !fcw_valid));

  // R3
  upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ck_cnt == BLK - 1) |=> fcw_valid);

  // R3
  no_extra_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && ck_cnt == BLK - 1) |=> !fcw_valid);

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !fcw_valid) |-> $stable(fcw_out));
endmodule

bind costas_qpsk_track costas_qpsk_track_chk #(
  .WW(WW), .BLK(BLK), .CARRIER_WORD(CARRIER_WORD)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fcw_out(fcw_out), .fcw_valid(fcw_valid)
);

// File: tb/costas_qpsk_track_tb.sv
module costas_qpsk_track_tb;
  localparam int DW = 32, WW = 32, CW = 16, P_SHIFT = 16, I_SHIFT = 20, BLK = 8;
  localparam logic [31:0] WC = 32'd660764199;
  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;

  logic clk = 0, rst = 1, in_valid = 0, coarse_load = 0, coarse_en = 0;
  logic [DW-1:0] i_in = '0, q_in = '0;
  logic [CW-1:0] prop_gain = 16'd1000, int_gain = 16'd200;
  logic [WW-1:0] coarse_word = '0;
  wire  [WW-1:0] fcw_out;
  wire           fcw_valid;

  int errors = 0, checks = 0;
  longint m_integ, m_acc, m_coarse, m_fcw;
  int m_cnt;
  bit m_upd;

  always #4 clk = ~clk;

  costas_qpsk_track u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .i_in(i_in), .q_in(q_in),
    .prop_gain(prop_gain), .int_gain(int_gain), .coarse_word(coarse_word),
    .coarse_load(coarse_load), .coarse_en(coarse_en),
    .fcw_out(fcw_out), .fcw_valid(fcw_valid)
  );

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic longint sat(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint perr(longint i, longint q);
    longint a = (i < 0) ? -q : q;
    longint b = (q < 0) ? -i : i;
    return a - b;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_integ = 0; m_acc = 0; m_coarse = 0; m_cnt = 0; m_fcw = longint'(WC); m_upd = 0;
    chk("R1 fcw_out", longint'(fcw_out), longint'(WC));
    chk("R1 fcw_valid", longint'(fcw_valid), 0);
  endtask

  task automatic push(longint i, longint q);
    longint p;
    in_valid = 1; i_in = i[DW-1:0]; q_in = q[DW-1:0];
    m_acc += perr(i, q);
    m_cnt++;
    m_upd = 0;
    if (m_cnt == BLK) begin
      p = sat((longint'($signed(prop_gain)) * m_acc) >>> P_SHIFT);
      m_integ = sat(m_integ + ((longint'($signed(int_gain)) * m_acc) >>> I_SHIFT));
      m_fcw = (longint'(WC) + p + m_integ + (coarse_en ? m_coarse : 0)) & 64'hFFFF_FFFF;
      m_cnt = 0; m_acc = 0; m_upd = 1;
    end
    @(negedge clk);
    in_valid = 0; i_in = $urandom; q_in = $urandom;
  endtask

  task automatic after_push(string tag);
    if (m_upd) begin
      chk({tag, " R3 strobe"}, longint'(fcw_valid), 1);
      chk({tag, " R7 word"}, longint'(fcw_out), m_fcw);
    end else begin
      chk({tag, " R3 no strobe"}, longint'(fcw_valid), 0);
      chk({tag, " R4 hold"}, longint'(fcw_out), m_fcw);
    end
  endtask

  task automatic run_block(string tag, longint i0, longint di, longint q0, longint dq, int gap);
    for (int k = 0; k < BLK; k++) begin
      push(i0 + k * di, q0 + k * dq);
      after_push(tag);
      repeat (gap) begin
        @(negedge clk);
        chk({tag, " R3 gap ignored"}, longint'(fcw_valid), 0);
      end
    end
    @(negedge clk);
    chk({tag, " R3 single pulse"}, longint'(fcw_valid), 0);
  endtask

  task automatic t_zero();
    run_block("R7 zero", 0, 0, 0, 0, 0);
    chk("R7 zero carrier", longint'(fcw_out), longint'(WC));
  endtask

  task automatic t_signs();
    run_block("R2 R5 R6 pp", 1000, 13, 300, -7, 0);
    run_block("R2 R5 R6 np", -5000, 100, 2000, 50, 0);
    run_block("R2 R5 R6 nn", -70000, 0, -123456, 11, 0);
    run_block("R2 R5 R6 pn", 900000, -3, -4000000, 0, 0);
    run_block("R2 zero arms", 0, 0, -7, 0, 0);
    run_block("R2 zero q", -9, 0, 0, 0, 0);
  endtask

  task automatic t_gaps();
    run_block("R3 gaps", 40000, 5, -15000, 9, 3);
  endtask

  task automatic t_coarse();
    @(negedge clk);
    coarse_word = 32'h0100_0000; coarse_load = 1;
    m_coarse = 64'h0100_0000;
    @(negedge clk);
    coarse_load = 0; coarse_word = 32'hDEAD_BEEF;
    coarse_en = 1;
    run_block("R8 coarse on", 2000, 0, 1000, 0, 0);
    coarse_en = 0;
    run_block("R8 coarse off", 2000, 0, 1000, 0, 0);
    coarse_en = 1;
    run_block("R8 coarse on again", 0, 0, 0, 0, 1);
  endtask

  task automatic t_sat();
    longint prev;
    do_reset();
    int_gain = 16'sd32767; prop_gain = 16'sd0;
    for (int b = 0; b < 12; b++) run_block("R6 R9 up", -(64'sd1 <<< 30), 0, 0, 0, 0);
    chk("R9 upper clamp", m_integ, MAXV);
    prev = longint'(fcw_out);
    run_block("R9 up hold", -(64'sd1 <<< 30), 0, 0, 0, 0);
    chk("R9 no wrap up", longint'(fcw_out), prev);
    do_reset();
    for (int b = 0; b < 12; b++) run_block("R6 R9 down", (64'sd1 <<< 30), 0, 0, 0, 0);
    chk("R9 lower clamp", m_integ, MINV);
    prev = longint'(fcw_out);
    run_block("R9 down hold", (64'sd1 <<< 30), 0, 0, 0, 0);
    chk("R9 no wrap down", longint'(fcw_out), prev);
    prop_gain = 16'sd1000; int_gain = 16'sd200;
  endtask

  task automatic t_midreset();
    do_reset();
    for (int k = 0; k < 5; k++) push(123456, -654321);
    do_reset();
    run_block("R10 fresh block", 3000, 1, 700, 2, 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_zero();
    t_signs();
    t_gaps();
    t_coarse();
    t_sat();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule